// File: doc/BRIEF.md
# Interrupt Coalescing Controller with Credit Accounting

This block drives one interrupt line on behalf of one event source. Each event pulse adds one credit to an outstanding-work counter. The line is raised only after a programmable holdoff timer has run down to zero. Software then handles the work and acknowledges it by writing back a number of credits. The same acknowledge write can also unmask the line and restart the holdoff.

Two holdoff modes are available. In absolute mode the timer starts once, at the first event of a burst. In quiet mode every event restarts the timer, so the line waits for a gap in activity. Software can mask the line directly. An optional auto-mask sets the mask by hardware when the line rises, so the handler can unmask it through the acknowledge write.

Software reaches the block through a simple word register port. Writes take effect on the clock edge that samples them. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_coalesce`

## Requirements
- R1: Registers decode on full byte addresses: holdoff 0x00 (bits 15:0, read/write), live timer 0x08 (read-only), mode 0x10 (bit 0), auto-mask 0x18 (bit 0), mask 0x20 (bit 0), credits 0x28 (read-only), acknowledge 0x30 (write-only), pending 0x38 (read-only). Unimplemented bits, the acknowledge register and unmapped addresses read as zero.
- R2: Each clock edge that samples `evt_i` high adds one credit, and the credit register at 0x28 returns the count not yet acknowledged.
- R3: The credit count saturates at 0xFFFF.
- R4: A write to 0x30 subtracts bits 15:0 from the credit count, with the result clamped at zero.
- R5: With mode bit 0 = 0 (absolute), an event seen while credits are zero loads the timer from the holdoff value, and later events do not reload it. With holdoff H, `irq_o` rises on the (H+1)th edge after the edge that sampled the first event.
- R6: With mode bit 0 = 1 (quiet), every event reloads the timer, so `irq_o` rises H+1 edges after the last event.
- R7: `irq_o` is a register that is high on the edge after a cycle in which credits are nonzero, the timer is zero and the mask is clear. It falls one edge after the mask sets or the credits reach zero.
- R8: Writing 1 to bit 0 of 0x20 masks the line, and writing 0 unmasks it.
- R9: Bit 16 set in an acknowledge write clears the mask.
- R10: Bit 17 set in an acknowledge write reloads the timer from the holdoff value.
- R11: With auto-mask bit 0 = 1, the mask is set on the same edge on which `irq_o` rises, so the line is high for exactly one cycle.
- R12: Bit 0 of 0x38 reads 1 when credits are nonzero and the timer is zero, regardless of the mask, and reading it changes no state.
- R13: After reset, the credits, timer, holdoff, mode, auto-mask, mask and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event pulse, one credit per sampled cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one cycle after `rd_en` |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions check several things on every cycle. The timer counts down by one unless it is loaded, and it takes the holdoff value whenever it is loaded. Credits never grow by more than one per cycle and never shrink without an acknowledge. The line stays low after any cycle with the mask set or no credits. Mask writes, unmask requests and auto-mask take effect on the next edge.

Only the bench scenarios can show the end-to-end latency differences between absolute and quiet holdoff for a spaced burst. The same applies to the one-cycle pulse under auto-mask, the clamp and saturation values of the counter, the timer reload seen through the live timer register, and the non-destructive pending read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets; software decodes these, so they are fixed.
  localparam int unsigned OFS_HOLDOFF  = 8'h00;
  localparam int unsigned OFS_TIMER    = 8'h08;
  localparam int unsigned OFS_MODE     = 8'h10;
  localparam int unsigned OFS_AUTOMASK = 8'h18;
  localparam int unsigned OFS_MASK     = 8'h20;
  localparam int unsigned OFS_CREDITS  = 8'h28;
  localparam int unsigned OFS_ACK      = 8'h30;
  localparam int unsigned OFS_PENDING  = 8'h38;

  // Flag positions inside an acknowledge write.
  localparam int unsigned ACK_UNMASK_BIT = 16;
  localparam int unsigned ACK_RELOAD_BIT = 17;

  typedef enum logic {
    TMODE_ABS   = 1'b0,
    TMODE_QUIET = 1'b1
  } tmode_e;

  typedef struct packed {
    tmode_e mode;
    logic   automask;
  } cfg_t;
endpackage

// File: rtl/irqc_credit.sv
module irqc_credit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             ack_valid_i,
  input  logic [CNT_W-1:0] ack_amount_i,
  output logic [CNT_W-1:0] credits_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] credits_q;
  logic [CNT_W:0]   sum_w;
  logic [CNT_W:0]   sub_w;
  logic [CNT_W:0]   diff_w;
  logic [CNT_W-1:0] credits_d;

  always_comb begin
    sum_w     = {1'b0, credits_q} + {{CNT_W{1'b0}}, evt_i};
    sub_w     = ack_valid_i ? {1'b0, ack_amount_i} : '0;
    diff_w    = (sum_w > sub_w) ? (sum_w - sub_w) : '0;
    credits_d = diff_w[CNT_W] ? MAXV : diff_w[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) credits_q <= '0;
    else     credits_q <= credits_d;
  end

  assign credits_o = credits_q;

  // R2
  credit_step_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, credits_q} <= ({1'b0, $past(credits_q)} + 1'b1)));

  // R4
  credit_nodrop_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_valid_i |=> (credits_q >= $past(credits_q)));
endmodule

// File: rtl/irqc_timer.sv
module irqc_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  irqc_pkg::tmode_e mode_i,
  input  logic             credits_zero_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] holdoff_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  import irqc_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             load_w;
  logic             evt_load_w;

  always_comb begin
    evt_load_w = evt_i && ((mode_i == TMODE_QUIET) || credits_zero_i);
    load_w     = reload_i || evt_load_w;
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_w)        cnt_q <= holdoff_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == '0);

  // R5
  timer_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q != '0) && !load_w) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R10
  timer_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_w |=> (cnt_q == $past(holdoff_i)));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  credits_i,
  input  logic [CNT_W-1:0]  timer_i,
  input  logic              pending_i,
  input  logic              autoset_i,
  output logic [CNT_W-1:0]  holdoff_o,
  output irqc_pkg::cfg_t    cfg_o,
  output logic              mask_o,
  output logic              ack_valid_o,
  output logic [CNT_W-1:0]  ack_amount_o,
  output logic              ack_reload_o
);
  import irqc_pkg::*;

  localparam logic [ADDR_W-1:0] A_HOLD  = ADDR_W'(OFS_HOLDOFF);
  localparam logic [ADDR_W-1:0] A_TIMER = ADDR_W'(OFS_TIMER);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_AMASK = ADDR_W'(OFS_AUTOMASK);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CRED  = ADDR_W'(OFS_CREDITS);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PENDING);

  logic [CNT_W-1:0]  holdoff_q;
  cfg_t              cfg_q;
  logic              mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rmux_w;
  logic              mask_wr_w;
  logic              unmask_req_w;
  logic              unused_wbits;

  assign mask_wr_w    = wr_en && (addr == A_MASK);
  assign ack_valid_o  = wr_en && (addr == A_ACK);
  assign ack_amount_o = wdata[CNT_W-1:0];
  assign unmask_req_w = ack_valid_o && wdata[ACK_UNMASK_BIT];
  assign ack_reload_o = ack_valid_o && wdata[ACK_RELOAD_BIT];
  assign unused_wbits = ^wdata[DATA_W-1:ACK_RELOAD_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      holdoff_q <= '0;
      cfg_q     <= '{mode: TMODE_ABS, automask: 1'b0};
    end else if (wr_en) begin
      if (addr == A_HOLD)  holdoff_q      <= wdata[CNT_W-1:0];
      if (addr == A_MODE)  cfg_q.mode     <= tmode_e'(wdata[0]);
      if (addr == A_AMASK) cfg_q.automask <= wdata[0];
    end
  end

  // Software writes take priority over the hardware auto-mask.
  always_ff @(posedge clk) begin
    if (rst)               mask_q <= 1'b0;
    else if (mask_wr_w)    mask_q <= wdata[0];
    else if (unmask_req_w) mask_q <= 1'b0;
    else if (autoset_i)    mask_q <= 1'b1;
  end

  always_comb begin
    rmux_w = '0;
    unique case (addr)
      A_HOLD:  rmux_w = DATA_W'(holdoff_q);
      A_TIMER: rmux_w = DATA_W'(timer_i);
      A_MODE:  rmux_w = DATA_W'(cfg_q.mode);
      A_AMASK: rmux_w = DATA_W'(cfg_q.automask);
      A_MASK:  rmux_w = DATA_W'(mask_q);
      A_CRED:  rmux_w = DATA_W'(credits_i);
      A_PEND:  rmux_w = DATA_W'(pending_i);
      default: rmux_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rmux_w;
  end

  assign rdata     = rdata_q;
  assign holdoff_o = holdoff_q;
  assign cfg_o     = cfg_q;
  assign mask_o    = mask_q;

  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    mask_wr_w |=> (mask_o == $past(wdata[0])));

  // R9
  ack_unmask_chk: assert property (@(posedge clk) disable iff (rst)
    unmask_req_w |=> !mask_o);

  // R11
  automask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (autoset_i && !mask_wr_w && !unmask_req_w) |=> mask_o);
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  import irqc_pkg::*;

  logic [CNT_W-1:0] credits_w;
  logic [CNT_W-1:0] timer_w;
  logic [CNT_W-1:0] holdoff_w;
  logic [CNT_W-1:0] ack_amount_w;
  logic             ack_valid_w;
  logic             ack_reload_w;
  logic             expired_w;
  logic             mask_w;
  logic             pending_w;
  logic             irq_d;
  logic             irq_q;
  logic             autoset_w;
  cfg_t             cfg_w;

  irqc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .credits_i(credits_w), .timer_i(timer_w),
    .pending_i(pending_w), .autoset_i(autoset_w), .holdoff_o(holdoff_w),
    .cfg_o(cfg_w), .mask_o(mask_w), .ack_valid_o(ack_valid_w),
    .ack_amount_o(ack_amount_w), .ack_reload_o(ack_reload_w)
  );

  irqc_credit #(.CNT_W(CNT_W)) u_credit (
    .clk(clk), .rst(rst), .evt_i(evt_i), .ack_valid_i(ack_valid_w),
    .ack_amount_i(ack_amount_w), .credits_o(credits_w)
  );

  irqc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .evt_i(evt_i), .mode_i(cfg_w.mode),
    .credits_zero_i(credits_w == '0), .reload_i(ack_reload_w),
    .holdoff_i(holdoff_w), .cnt_o(timer_w), .expired_o(expired_w)
  );

  assign pending_w = (credits_w != '0) && expired_w;
  assign irq_d     = pending_w && !mask_w;
  assign autoset_w = cfg_w.automask && irq_d && !irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R7
  masked_low_chk: assert property (@(posedge clk) disable iff (rst)
    mask_w |=> !irq_o);

  // R7
  nocredit_low_chk: assert property (@(posedge clk) disable iff (rst)
    (credits_w == '0) |=> !irq_o);

  // R7
  timer_running_low_chk: assert property (@(posedge clk) disable iff (rst)
    !expired_w |=> !irq_o);
endmodule

// File: tb/irq_coalesce_test.sv
module irq_coalesce_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_i = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_coalesce uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // {events, ack amount, expected credits}
  localparam logic [23:0] VEC [6] = '{
    {8'd5, 8'd2,  8'd3},
    {8'd3, 8'd3,  8'd0},
    {8'd2, 8'd10, 8'd0},
    {8'd0, 8'd0,  8'd0},
    {8'd7, 8'd0,  8'd7},
    {8'd9, 8'd1,  8'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic run_events(input int count, input int spacing, input int ncyc,
                            output logic [63:0] hist);
    hist = '0;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      evt_i = ((cyc / spacing) < count) && ((cyc % spacing) == 0);
      @(posedge clk); @(negedge clk);
      evt_i = 1'b0;
      hist[cyc] = irq_o;
    end
  endtask

  function automatic int first_high(input logic [63:0] h);
    for (int i = 0; i < 64; i++) if (h[i]) return i;
    return -1;
  endfunction

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] h;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R13 reset state
    chk("R13 irq", {31'd0, irq_o}, 32'd0);
    rd(8'h28, d); chk("R13 credits", d, 0);
    rd(8'h08, d); chk("R13 timer", d, 0);
    rd(8'h00, d); chk("R13 holdoff", d, 0);
    rd(8'h20, d); chk("R13 mask", d, 0);
    rd(8'h10, d); chk("R13 mode", d, 0);

    // R1 decode and zero fill
    wr(8'h00, 32'hABCD_1234); rd(8'h00, d); chk("R1 holdoff width", d, 32'h1234);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R1 mode bit", d, 1);
    wr(8'h10, 32'h0);
    rd(8'h30, d); chk("R1 ack reads zero", d, 0);
    rd(8'h3C, d); chk("R1 unmapped", d, 0);
    wr(8'h20, 32'h1);  // keep the line quiet for the table

    // R2 / R4 table
    foreach (VEC[i]) begin
      wr(8'h30, 32'h0000_FFFF);
      run_events(int'(VEC[i][23:16]), 1, int'(VEC[i][23:16]) + 1, h);
      rd(8'h28, d); chk("R2 count events", d, {24'd0, VEC[i][23:16]});
      wr(8'h30, {24'd0, VEC[i][15:8]});
      rd(8'h28, d); chk("R4 ack clamp", d, {24'd0, VEC[i][7:0]});
    end

    // R5 absolute holdoff
    wr(8'h30, 32'h0000_FFFF);
    wr(8'h20, 32'h0);
    wr(8'h00, 32'd4);
    step(6);
    run_events(3, 2, 12, h);
    chk("R5 absolute latency", first_high(h), 5);
    rd(8'h38, d); chk("R12 pending", d, 1);
    rd(8'h38, d); chk("R12 pending not cleared", d, 1);
    wr(8'h30, 32'd3);
    step(1);
    chk("R7 drop on zero credits", {31'd0, irq_o}, 0);

    // R6 quiet holdoff
    wr(8'h10, 32'h1);
    step(6);
    run_events(3, 2, 14, h);
    chk("R6 quiet latency", first_high(h), 9);
    wr(8'h30, 32'h0000_FFFF);
    wr(8'h10, 32'h0);

    // R10 timer reload through acknowledge
    wr(8'h00, 32'd10);
    step(2);
    run_events(1, 1, 3, h);
    wr(8'h30, 32'h0002_0000);
    rd(8'h08, d); chk("R10 reload", d, 10);
    wr(8'h30, 32'h0000_FFFF);

    // R8 / R9 mask control
    wr(8'h00, 32'd0);
    wr(8'h20, 32'h1);
    step(2);
    run_events(1, 1, 4, h);
    chk("R8 masked stays low", h[31:0], 0);
    rd(8'h38, d); chk("R12 pending while masked", d, 1);
    wr(8'h30, 32'h0001_0000);
    step(1);
    chk("R9 unmask raises line", {31'd0, irq_o}, 1);
    rd(8'h20, d); chk("R9 mask cleared", d, 0);
    wr(8'h20, 32'h1); step(1);
    chk("R8 mask drops line", {31'd0, irq_o}, 0);
    wr(8'h20, 32'h0); step(1);
    chk("R8 unmask raises line", {31'd0, irq_o}, 1);
    wr(8'h30, 32'h0000_FFFF); step(1);
    chk("R7 low after ack all", {31'd0, irq_o}, 0);

    // R11 auto-mask one-cycle pulse
    wr(8'h18, 32'h1);
    run_events(1, 1, 5, h);
    chk("R11 single pulse", h[4:0], 5'b00010);
    rd(8'h20, d); chk("R11 mask set", d, 1);
    wr(8'h18, 32'h0);

    // R3 saturation
    wr(8'h30, 32'h0000_FFFF);
    evt_i = 1'b1;
    step(65540);
    evt_i = 1'b0;
    rd(8'h28, d); chk("R3 saturate", d, 32'h0000_FFFF);
    wr(8'h30, 32'd5);
    rd(8'h28, d); chk("R4 ack from saturated", d, 32'h0000_FFFA);

    done = 1;
    summary();
  end
endmodule